// File: doc/BRIEF.md
# Banked Ones-Count Tag Matcher

This block is a content-addressable tag store whose entries are spread over several banks. Each bank is split further into subbanks. The bank for a tag comes from the number of one bits in the tag, which is computed as the tag arrives. The low bits of that count pick the bank. Two fixed low tag bits pick the subbank inside that bank. Each entry keeps a valid flag, the upper count bits and the tag with the subbank bits removed. The removed bits are not needed because the subbank position already implies them.

On a search, the block compares the key only in the one subbank that the tag selects. All other subbanks stay idle that cycle. A lowest-index priority pick turns the matches into a location. On a write, the tag goes into the lowest free slot of the subbank that its own count and low bits select. If that subbank has no free slot, the block reports it as full and stores nothing.

Both request ports and both response ports use valid/ready handshakes. A request is taken on a rising edge where its valid and ready are both high. Each response register holds one result. The matching request ready is low only while that register holds a result that has not been taken. A held result stays unchanged until the consumer raises ready. A request that is not accepted may be withdrawn or changed.

Top module: `pcam_top`

## Requirements
- R1: A tag's location is the 8-bit value {bank[7:6], subbank[5:4], index[3:0]}. The bank is the two least significant bits of the tag's one-bit count, and the subbank is tag bits [1:0]. For example, 16'hFFFF goes to 8'h30, 16'h0001 to 8'h50, 16'h00F3 to 8'hB0 and 16'h0007 to 8'hF0.
- R2: A search for a stored tag returns hit = 1 and the location that the write of that tag reported.
- R3: A search for a tag that is not stored returns hit = 0 and location 0. This includes a search in an empty subbank and a search for an absent tag in an occupied subbank.
- R4: When several valid entries of the selected subbank hold the searched tag, the lowest index is returned.
- R5: A write stores the tag in the lowest-index free slot of its subbank and reports full = 0 together with that location.
- R6: A write to a subbank whose 16 slots are all valid reports full = 1 and location 0, and changes no entry. A later search for that tag misses, and other subbanks still accept writes.
- R7: A search result appears on the response port in the cycle after the request is accepted. A write acknowledgement likewise appears in the cycle after its request is accepted.
- R8: While a search result is held with res_ready low, srch_ready is low and res_hit and res_addr stay stable. A new request is accepted on the edge where the held result is taken.
- R9: After reset, both response valids are low, both request readies are high and no entry is valid.
- R10: When a search and a write are accepted on the same edge, the search sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_valid | input | 1 | Search request present |
| srch_ready | output | 1 | Search request can be taken |
| srch_tag | input | 16 | Tag to look up |
| res_valid | output | 1 | Search result present |
| res_ready | input | 1 | Consumer takes the search result |
| res_hit | output | 1 | Tag was found |
| res_addr | output | 8 | Location {bank, subbank, index}, 0 on a miss |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be taken |
| wr_tag | input | 16 | Tag to store |
| wack_valid | output | 1 | Write acknowledgement present |
| wack_ready | input | 1 | Consumer takes the acknowledgement |
| wack_full | output | 1 | Target subbank had no free slot |
| wack_addr | output | 8 | Location written, 0 when full |

## Verification
The properties assume that reset is applied before any traffic and that the valid and ready inputs are never unknown once reset ends. They do not assume that a request stays unchanged while it waits for ready. The stimulus changes inputs only on the falling clock edge and keeps both ready inputs high, except in one deliberate stall window. Within that window the stall and the release are checked directly at the ports instead of through the scoreboard. The fill and duplicate tags come from 14-bit patterns whose one-count is a multiple of four, so every one of them falls into bank 0, subbank 0.

// File: rtl/pcam_pkg.sv
package pcam_pkg;
  parameter int unsigned DEF_TAG_W   = 16;
  parameter int unsigned DEF_BANK_W  = 2;
  parameter int unsigned DEF_SUB_W   = 2;
  parameter int unsigned DEF_ENTRIES = 16;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_SEARCH = 2'b01,
    OP_WRITE  = 2'b10,
    OP_BOTH   = 2'b11
  } pcam_op_e;
endpackage

// File: rtl/pcam_onescount.sv
module pcam_onescount #(
  parameter int unsigned W = 16,
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     din,
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CNT_W'(din[i]);
    end
  end
endmodule

// File: rtl/pcam_lsb_pick.sv
module pcam_lsb_pick #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pcam_subbank.sv
module pcam_subbank #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned KEY_W   = 17,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_en,
  input  logic [KEY_W-1:0] cmp_key,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = cmp_en && valid_q[i] && (key_q[i] == cmp_key);
  end

  pcam_lsb_pick #(.N(ENTRIES)) u_hit_pick (
    .vec(match), .any(hit), .idx(hit_idx)
  );

  pcam_lsb_pick #(.N(ENTRIES)) u_free_pick (
    .vec(~valid_q), .any(free_any), .idx(free_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) key_q[free_idx] <= wr_key;
  end

  // R6
  wr_only_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> free_any);

  // R5
  wr_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

  // R4
  hit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> valid_q[hit_idx]);
endmodule

// File: rtl/pcam_top.sv
module pcam_top #(
  parameter int unsigned TAG_W   = pcam_pkg::DEF_TAG_W,
  parameter int unsigned BANK_W  = pcam_pkg::DEF_BANK_W,
  parameter int unsigned SUB_W   = pcam_pkg::DEF_SUB_W,
  parameter int unsigned ENTRIES = pcam_pkg::DEF_ENTRIES,
  localparam int unsigned CNT_W  = $clog2(TAG_W + 1),
  localparam int unsigned UP_W   = CNT_W - BANK_W,
  localparam int unsigned KEY_W  = UP_W + TAG_W - SUB_W,
  localparam int unsigned SEL_W  = BANK_W + SUB_W,
  localparam int unsigned NSB    = 1 << SEL_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned ADDR_W = SEL_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srch_valid,
  output logic              srch_ready,
  input  logic [TAG_W-1:0]  srch_tag,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [ADDR_W-1:0] res_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [TAG_W-1:0]  wr_tag,
  output logic              wack_valid,
  input  logic              wack_ready,
  output logic              wack_full,
  output logic [ADDR_W-1:0] wack_addr
);
  import pcam_pkg::*;

  logic [CNT_W-1:0] s_cnt, w_cnt;
  logic [SEL_W-1:0] s_sel, w_sel;
  logic [KEY_W-1:0] s_key, w_key;
  logic             srch_fire, wr_fire;
  pcam_op_e         op;

  logic             sb_hit  [NSB];
  logic [IDX_W-1:0] sb_hidx [NSB];
  logic             sb_free [NSB];
  logic [IDX_W-1:0] sb_fidx [NSB];

  logic             s_hit, w_free;
  logic [IDX_W-1:0] s_idx, w_idx;

  pcam_onescount #(.W(TAG_W)) u_srch_cnt (.din(srch_tag), .cnt(s_cnt));
  pcam_onescount #(.W(TAG_W)) u_wr_cnt   (.din(wr_tag),   .cnt(w_cnt));

  assign s_sel = {s_cnt[BANK_W-1:0], srch_tag[SUB_W-1:0]};
  assign w_sel = {w_cnt[BANK_W-1:0], wr_tag[SUB_W-1:0]};
  assign s_key = {s_cnt[CNT_W-1:BANK_W], srch_tag[TAG_W-1:SUB_W]};
  assign w_key = {w_cnt[CNT_W-1:BANK_W], wr_tag[TAG_W-1:SUB_W]};

  assign srch_ready = !res_valid || res_ready;
  assign wr_ready   = !wack_valid || wack_ready;
  assign srch_fire  = srch_valid && srch_ready;
  assign wr_fire    = wr_valid && wr_ready;
  assign op         = pcam_op_e'({wr_fire, srch_fire});

  for (genvar g = 0; g < NSB; g++) begin : g_sb
    logic en_cmp, en_wr;
    assign en_cmp = op[0] && (s_sel == SEL_W'(g));
    assign en_wr  = op[1] && (w_sel == SEL_W'(g)) && sb_free[g];

    pcam_subbank #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_en   (en_cmp),
      .cmp_key  (s_key),
      .wr_en    (en_wr),
      .wr_key   (w_key),
      .hit      (sb_hit[g]),
      .hit_idx  (sb_hidx[g]),
      .free_any (sb_free[g]),
      .free_idx (sb_fidx[g])
    );
  end

  assign s_hit  = sb_hit[s_sel];
  assign s_idx  = sb_hidx[s_sel];
  assign w_free = sb_free[w_sel];
  assign w_idx  = sb_fidx[w_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_addr  <= '0;
    end else if (op == OP_SEARCH || op == OP_BOTH) begin
      res_valid <= 1'b1;
      res_hit   <= s_hit;
      res_addr  <= s_hit ? {s_sel, s_idx} : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wack_valid <= 1'b0;
      wack_full  <= 1'b0;
      wack_addr  <= '0;
    end else if (op == OP_WRITE || op == OP_BOTH) begin
      wack_valid <= 1'b1;
      wack_full  <= !w_free;
      wack_addr  <= w_free ? {w_sel, w_idx} : '0;
    end else if (wack_ready) begin
      wack_valid <= 1'b0;
    end
  end

  // R7
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && srch_ready) |=> res_valid);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_addr)));

  // R3
  miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_addr == '0));
endmodule

// File: tb/test_pcam_top.sv
`timescale 1ns/1ps
module test_pcam_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srch_valid = 1'b0, res_ready = 1'b1, wr_valid = 1'b0, wack_ready = 1'b1;
  logic [15:0] srch_tag = '0, wr_tag = '0;
  logic        srch_ready, res_valid, res_hit, wr_ready, wack_valid, wack_full;
  logic [7:0]  res_addr, wack_addr;

  int n_checks = 0, n_fail = 0;
  bit mon_en = 1'b1;
  bit done = 1'b0;

  bit          mv [256];
  logic [15:0] mt [256];

  bit       q_hit  [$];
  bit [7:0] q_addr [$];
  string    q_req  [$];
  bit [7:0] last_waddr;

  always #10 clk = ~clk;

  pcam_top i_pcam_top (
    .clk(clk), .rst_n(rst_n),
    .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_tag(srch_tag),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_addr(res_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tag(wr_tag),
    .wack_valid(wack_valid), .wack_ready(wack_ready), .wack_full(wack_full), .wack_addr(wack_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit [3:0] sel_of(input logic [15:0] t);
    int c = $countones(t);
    return {c[1:0], t[1:0]};
  endfunction

  task automatic model_search(input logic [15:0] t, output bit h, output bit [7:0] a);
    bit [3:0] s = sel_of(t);
    h = 1'b0; a = '0;
    for (int i = 0; i < 16; i++) begin
      if (!h && mv[s*16+i] && mt[s*16+i] == t) begin
        h = 1'b1; a = {s, 4'(i)};
      end
    end
  endtask

  task automatic model_write(input logic [15:0] t, output bit f, output bit [7:0] a);
    bit [3:0] s = sel_of(t);
    bit got = 1'b0;
    a = '0;
    for (int i = 0; i < 16; i++) begin
      if (!got && !mv[s*16+i]) begin
        got = 1'b1; mv[s*16+i] = 1'b1; mt[s*16+i] = t; a = {s, 4'(i)};
      end
    end
    f = !got;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en && rst_n && res_valid && res_ready) begin
      if (q_hit.size() == 0) begin
        chk(1'b0, "R7 unexpected result", 1, 0);
      end else begin
        bit eh; bit [7:0] ea; string r;
        eh = q_hit.pop_front(); ea = q_addr.pop_front(); r = q_req.pop_front();
        chk(res_hit == eh, r, res_hit, eh);
        chk(res_addr == ea, r, res_addr, ea);
      end
    end
  end

  // called at a falling edge
  task automatic cycle(input bit ds, input logic [15:0] st, input string sreq,
                       input bit dw, input logic [15:0] wt, input string wreq);
    bit eh, ef; bit [7:0] ea, wa;
    if (ds) begin
      model_search(st, eh, ea);
      q_hit.push_back(eh); q_addr.push_back(ea); q_req.push_back(sreq);
      srch_valid = 1'b1; srch_tag = st;
    end
    if (dw) begin
      model_write(wt, ef, wa);
      wr_valid = 1'b1; wr_tag = wt;
    end
    @(negedge clk);
    srch_valid = 1'b0; wr_valid = 1'b0;
    if (dw) begin
      chk(wack_valid == 1'b1, {wreq, " ack valid"}, wack_valid, 1);
      chk(wack_full == ef, {wreq, " full"}, wack_full, ef);
      chk(wack_addr == wa, {wreq, " addr"}, wack_addr, wa);
      last_waddr = wack_addr;
    end
  endtask

  task automatic srch(input logic [15:0] t, input string r);
    cycle(1'b1, t, r, 1'b0, '0, "");
  endtask

  task automatic wr(input logic [15:0] t, input string r);
    cycle(1'b0, '0, "", 1'b1, t, r);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [15:0] fill [17];
    int nf;
    do_reset();

    // R9 reset state
    chk(res_valid == 1'b0, "R9 res_valid", res_valid, 0);
    chk(wack_valid == 1'b0, "R9 wack_valid", wack_valid, 0);
    chk(srch_ready == 1'b1, "R9 srch_ready", srch_ready, 1);
    chk(wr_ready == 1'b1, "R9 wr_ready", wr_ready, 1);

    // R3 empty subbank miss, R7 single-cycle latency
    mon_en = 1'b0;
    srch_valid = 1'b1; srch_tag = 16'h1234;
    @(negedge clk); srch_valid = 1'b0;
    chk(res_valid == 1'b1, "R7 result next cycle", res_valid, 1);
    chk(res_hit == 1'b0, "R3 empty miss", res_hit, 0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 result drops after taken", res_valid, 0);
    mon_en = 1'b1;

    // R1 placement by ones count and low bits
    wr(16'h0000, "R5 write"); chk(last_waddr == 8'h00, "R1 loc 0000", last_waddr, 8'h00);
    wr(16'hFFFF, "R5 write"); chk(last_waddr == 8'h30, "R1 loc FFFF", last_waddr, 8'h30);
    wr(16'h0001, "R5 write"); chk(last_waddr == 8'h50, "R1 loc 0001", last_waddr, 8'h50);
    wr(16'h8000, "R5 write"); chk(last_waddr == 8'h40, "R1 loc 8000", last_waddr, 8'h40);
    wr(16'h00F3, "R5 write"); chk(last_waddr == 8'hB0, "R1 loc 00F3", last_waddr, 8'hB0);
    wr(16'h0007, "R5 write"); chk(last_waddr == 8'hF0, "R1 loc 0007", last_waddr, 8'hF0);

    // R2 back-to-back hits
    srch(16'h0000, "R2 hit"); srch(16'hFFFF, "R2 hit"); srch(16'h0001, "R2 hit");
    srch(16'h8000, "R2 hit"); srch(16'h00F3, "R2 hit"); srch(16'h0007, "R2 hit");
    // R3 absent tag in occupied subbank
    srch(16'h0100, "R3 absent");
    srch(16'h4000, "R3 absent");

    // R4 duplicate: second copy at index 1, search returns index 0
    wr(16'h8000, "R5 dup write"); chk(last_waddr == 8'h41, "R5 second slot", last_waddr, 8'h41);
    srch(16'h8000, "R4 lowest index");

    // R6 fill bank 0 subbank 0
    nf = 0;
    for (int v = 1; v < 16384 && nf < 16; v++) begin
      if (($countones(v) % 4) == 0) begin
        fill[nf] = {v[13:0], 2'b00}; nf++;
      end
    end
    for (int i = 0; i < 15; i++) wr(fill[i], "R5 fill");
    chk(last_waddr == 8'h0F, "R5 last slot", last_waddr, 8'h0F);
    wr(fill[15], "R6 full write");
    chk(wack_full == 1'b1, "R6 full flag", wack_full, 1);
    srch(fill[15], "R6 not stored");
    srch(fill[14], "R2 fill hit");
    wr(16'h0002, "R6 other subbank ok");

    // R10 same-edge search and write of the same new tag
    cycle(1'b1, 16'h0300, "R10 search sees old", 1'b1, 16'h0300, "R10 write");
    srch(16'h0300, "R10 now stored");

    // R8 back-pressure, checked directly
    @(negedge clk);
    mon_en = 1'b0;
    res_ready = 1'b0; srch_valid = 1'b1; srch_tag = 16'hFFFF;
    @(negedge clk);
    chk(res_valid && res_hit && res_addr == 8'h30, "R8 held result", res_addr, 8'h30);
    chk(srch_ready == 1'b0, "R8 ready low", srch_ready, 0);
    srch_tag = 16'h5555;
    @(negedge clk);
    chk(res_valid && res_hit && res_addr == 8'h30, "R8 still held", res_addr, 8'h30);
    chk(srch_ready == 1'b0, "R8 ready still low", srch_ready, 0);
    res_ready = 1'b1;
    @(negedge clk);
    srch_valid = 1'b0;
    chk(res_valid && !res_hit, "R8 next request taken at release", res_hit, 0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 drained", res_valid, 0);
    mon_en = 1'b1;

    // R9 reset clears contents
    do_reset();
    srch(16'hFFFF, "R9 cleared");
    srch(16'h0000, "R9 cleared");
    @(negedge clk);
    @(negedge clk);

    chk(q_hit.size() == 0, "R7 results outstanding", q_hit.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule